// File: doc/BRIEF.md
# Immediate Logic and Shift Unit

This block is a purely combinational piece of the execute stage of a 32-bit RISC core. Each cycle it receives the decoded 32-bit instruction word together with the values of its two source registers. It then returns the 32-bit result for one of a small group of operations: load of an upper immediate, add of a sign-extended immediate, AND and OR with a zero-extended immediate, and six shifts. The shifts go left logically, right logically or right arithmetically. Each shift takes its amount either from a 5-bit field in the instruction or from the low bits of a register.

The unit reads the opcode and function fields itself. It raises `valid` only for the encodings it implements. For any other word it drives a zero result, so the core can merge it with other execute units. The register file, writeback, overflow traps and all other arithmetic are left to other blocks.

Top module: `imm_shift_unit`

## Requirements
- R1: Opcode 0x0F (bits 31:26) puts instruction bits 15:0 into result bits 31:16 and clears result bits 15:0; no register value has any effect.
- R2: Opcode 0x0C returns `rs_val` ANDed with the 16-bit immediate (bits 15:0) padded with sixteen zero bits on the left.
- R3: Opcode 0x0D returns `rs_val` ORed with the zero-padded 16-bit immediate, so result bits 31:16 equal those of `rs_val`.
- R4: Opcode 0x08 returns `rs_val` plus the sign-extended 16-bit immediate, modulo 2^32, with no other indication on overflow.
- R5: With opcode 0x00, funct (bits 5:0) 0x00, 0x02 and 0x03 shift `rt_val` left logically, right logically and right arithmetically by the amount in bits 10:6. The rs field and `rs_val` have no effect.
- R6: With opcode 0x00, funct 0x04, 0x06 and 0x07 perform the same three shifts of `rt_val`. The amount is `rs_val[4:0]`; `rs_val[31:5]` and instruction bits 10:6 have no effect.
- R7: Logical shifts fill vacated bit positions with zeros. The arithmetic right shift fills them with bit 31 of `rt_val`. An amount of zero returns `rt_val` unchanged.
- R8: Every other opcode, and every other funct value under opcode 0x00, drives `valid` low and `result` to zero. All encodings named in R1 to R6 drive `valid` high.
- R9: A left shift of 0x00000077 by 3 gives 0x000003B8, and a logical right shift of 0x00000003 by 2 gives 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word: opcode, register fields, shift amount, funct or immediate |
| rs_val | input | 32 | Value of the first source register (immediate operand partner, variable shift amount) |
| rt_val | input | 32 | Value of the second source register (data shifted by all shift forms) |
| result | output | 32 | Computed result, zero when the encoding is not supported |
| valid | output | 1 | High when the instruction word is one this unit executes |

## Verification
Every R-format word carries both a shift-amount field and a register whose low bits could also give an amount. The two amount sources are therefore present together on every shift, and the decode must pick exactly one of them. The bench provokes the conflict by setting the field and the register to different non-zero amounts. It also fills the ignored upper register bits and the unused rs field with ones, on both the fixed and the variable forms. It judges each result against a shift computed only from the source that the requirement names. A wrong choice then shows up as a shift by the wrong amount.

// File: rtl/isu_pkg.sv
package isu_pkg;

    localparam int XLEN    = 32;
    localparam int IMM_W   = 16;
    localparam int OPC_W   = 6;
    localparam int FN_W    = 6;
    localparam int OPC_LSB = 26;
    localparam int AMT_LSB = 6;

    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'h00;
    localparam logic [OPC_W-1:0] OPC_ADDI    = 6'h08;
    localparam logic [OPC_W-1:0] OPC_ANDI    = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI     = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_LUI     = 6'h0F;

    localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
    localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
    localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
    localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
    localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
    localparam logic [FN_W-1:0] FN_SRAV = 6'h07;

    typedef enum logic [2:0] {
        K_NONE,
        K_LUI,
        K_ADDI,
        K_ANDI,
        K_ORI,
        K_SLL,
        K_SRL,
        K_SRA
    } isu_kind_e;

    typedef enum logic [1:0] {
        DIR_LEFT,
        DIR_RLOG,
        DIR_RARI
    } isu_dir_e;

    typedef struct packed {
        isu_kind_e kind;
        logic      amt_from_reg;
        logic      valid;
    } isu_dec_t;

endpackage

// File: rtl/isu_decode.sv
module isu_decode
    import isu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] instr,
    output isu_dec_t     dec
);

    logic [OPC_W-1:0] opc;
    logic [FN_W-1:0]  fn;
    isu_dec_t         dec_d;
    logic             unused_fields;

    assign opc           = instr[OPC_LSB +: OPC_W];
    assign fn            = instr[FN_W-1:0];
    assign unused_fields = ^instr[OPC_LSB-1:FN_W];

    always_comb begin
        dec_d = '{kind: K_NONE, amt_from_reg: 1'b0, valid: 1'b0};
        unique case (opc)
            OPC_LUI:  dec_d.kind = K_LUI;
            OPC_ADDI: dec_d.kind = K_ADDI;
            OPC_ANDI: dec_d.kind = K_ANDI;
            OPC_ORI:  dec_d.kind = K_ORI;
            OPC_SPECIAL: begin
                unique case (fn)
                    FN_SLL:  dec_d.kind = K_SLL;
                    FN_SRL:  dec_d.kind = K_SRL;
                    FN_SRA:  dec_d.kind = K_SRA;
                    FN_SLLV: begin
                        dec_d.kind         = K_SLL;
                        dec_d.amt_from_reg = 1'b1;
                    end
                    FN_SRLV: begin
                        dec_d.kind         = K_SRL;
                        dec_d.amt_from_reg = 1'b1;
                    end
                    FN_SRAV: begin
                        dec_d.kind         = K_SRA;
                        dec_d.amt_from_reg = 1'b1;
                    end
                    default: dec_d.kind = K_NONE;
                endcase
            end
            default: dec_d.kind = K_NONE;
        endcase
        dec_d.valid = (dec_d.kind != K_NONE);
    end

    assign dec = dec_d;

    // R6: a register-sourced amount only arises under the shift opcode
    always_comb begin
        if (dec_d.amt_from_reg) begin
            a_r6_reg_amt_special: assert (opc == OPC_SPECIAL)
                else $error("register amount selected outside shift opcode");
        end
    end

endmodule

// File: rtl/isu_imm_ext.sv
module isu_imm_ext
    import isu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  logic [IW-1:0] imm,
    output logic [W-1:0]  zext,
    output logic [W-1:0]  sext,
    output logic [W-1:0]  upper
);

    localparam int PAD_W = W - IW;

    always_comb begin
        zext  = {{PAD_W{1'b0}}, imm};
        sext  = {{PAD_W{imm[IW-1]}}, imm};
        upper = {imm, {PAD_W{1'b0}}};
    end

endmodule

// File: rtl/isu_shifter.sv
module isu_shifter
    import isu_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    data,
    input  logic [SH_W-1:0] amt,
    input  isu_dir_e        dir,
    output logic [W-1:0]    res
);

    logic [W-1:0] rev_in;
    logic [W-1:0] rev_out;
    logic [W-1:0] stg [SH_W+1];
    logic         fill;
    logic         go_left;

    assign go_left = (dir == DIR_LEFT);
    assign fill    = (dir == DIR_RARI) ? data[W-1] : 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rev_in[i]  = data[W-1-i];
        assign rev_out[i] = stg[SH_W][W-1-i];
    end

    assign stg[0] = go_left ? rev_in : data;

    // log-depth right shifter; left shifts run through bit reversal
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int S = 1 << k;
        assign stg[k+1] = amt[k] ? {{S{fill}}, stg[k][W-1:S]} : stg[k];
    end

    assign res = go_left ? rev_out : stg[SH_W];

    // R7: vacated positions carry the fill value
    always_comb begin
        if (amt != '0) begin
            if (dir == DIR_LEFT) begin
                a_r7_left_zero_fill: assert (res[0] == 1'b0)
                    else $error("left shift did not clear bit 0");
            end
            if (dir == DIR_RLOG) begin
                a_r7_rlog_zero_fill: assert (res[W-1] == 1'b0)
                    else $error("logical right shift did not clear msb");
            end
        end
        if (dir == DIR_RARI) begin
            a_r7_rari_sign_fill: assert (res[W-1] == data[W-1])
                else $error("arithmetic right shift lost the sign");
        end
    end

endmodule

// File: rtl/imm_shift_unit.sv
module imm_shift_unit
    import isu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  logic [W-1:0] instr,
    input  logic [W-1:0] rs_val,
    input  logic [W-1:0] rt_val,
    output logic [W-1:0] result,
    output logic         valid
);

    localparam int SH_W = $clog2(W);

    typedef struct packed {
        logic [W-1:0] result;
        logic         valid;
    } isu_out_t;

    isu_dec_t        dec;
    logic [W-1:0]    zext;
    logic [W-1:0]    sext;
    logic [W-1:0]    upper;
    logic [W-1:0]    sh_res;
    logic [SH_W-1:0] sh_amt_d;
    isu_dir_e        sh_dir_d;
    isu_out_t        out_d;

    isu_decode #(.W(W)) u_decode (
        .instr (instr),
        .dec   (dec)
    );

    isu_imm_ext #(.W(W), .IW(IW)) u_imm_ext (
        .imm   (instr[IW-1:0]),
        .zext  (zext),
        .sext  (sext),
        .upper (upper)
    );

    always_comb begin
        sh_amt_d = dec.amt_from_reg ? rs_val[SH_W-1:0]
                                    : instr[AMT_LSB +: SH_W];
        unique case (dec.kind)
            K_SRL:   sh_dir_d = DIR_RLOG;
            K_SRA:   sh_dir_d = DIR_RARI;
            default: sh_dir_d = DIR_LEFT;
        endcase
    end

    isu_shifter #(.W(W), .SH_W(SH_W)) u_shifter (
        .data (rt_val),
        .amt  (sh_amt_d),
        .dir  (sh_dir_d),
        .res  (sh_res)
    );

    always_comb begin
        out_d.valid = dec.valid;
        unique case (dec.kind)
            K_LUI:                out_d.result = upper;
            K_ADDI:               out_d.result = rs_val + sext;
            K_ANDI:               out_d.result = rs_val & zext;
            K_ORI:                out_d.result = rs_val | zext;
            K_SLL, K_SRL, K_SRA:  out_d.result = sh_res;
            default:              out_d.result = '0;
        endcase
    end

    assign result = out_d.result;
    assign valid  = out_d.valid;

    // R1 / R2 / R3: immediate placement seen at the result
    always_comb begin
        if (dec.kind == K_LUI) begin
            a_r1_lui_low_zero: assert (out_d.result[IW-1:0] == '0)
                else $error("upper-immediate load left low half non-zero");
        end
        if (dec.kind == K_ANDI) begin
            a_r2_andi_high_zero: assert (out_d.result[W-1:IW] == '0)
                else $error("and-immediate produced high bits");
        end
        if (dec.kind == K_ORI) begin
            a_r3_ori_keeps_src: assert ((out_d.result & rs_val) == rs_val)
                else $error("or-immediate dropped a source bit");
        end
    end

endmodule

// File: tb/imm_shift_unit_bench.sv
module imm_shift_unit_bench;

    typedef struct {
        logic [31:0] res;
        logic        v;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr  = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] result;
    logic        valid;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    imm_shift_unit u_imm_shift_unit (
        .instr  (instr),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .result (result),
        .valid  (valid)
    );

    function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] rtype(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] sh, input logic [5:0] fn);
        return {6'h00, rs, rt, 5'd9, sh, fn};
    endfunction

    // reference model written from the requirements
    function automatic logic [32:0] model(input logic [31:0] ins, input logic [31:0] a,
                                          input logic [31:0] b);
        logic [5:0]  op;
        logic [5:0]  fn;
        logic [15:0] im;
        logic [4:0]  amt;
        op = ins[31:26];
        fn = ins[5:0];
        im = ins[15:0];
        case (op)
            6'h0F: return {1'b1, im, 16'h0000};
            6'h08: return {1'b1, a + {{16{im[15]}}, im}};
            6'h0C: return {1'b1, a & {16'h0000, im}};
            6'h0D: return {1'b1, a | {16'h0000, im}};
            6'h00: begin
                amt = fn[2] ? a[4:0] : ins[10:6];
                case (fn)
                    6'h00, 6'h04: return {1'b1, b << amt};
                    6'h02, 6'h06: return {1'b1, b >> amt};
                    6'h03, 6'h07: return {1'b1, 32'($signed(b) >>> amt)};
                    default:      return 33'd0;
                endcase
            end
            default: return 33'd0;
        endcase
    endfunction

    task automatic drive_exp(input logic [31:0] ins, input logic [31:0] a,
                             input logic [31:0] b, input logic ev,
                             input logic [31:0] er, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        instr  = ins;
        rs_val = a;
        rt_val = b;
        e.res  = er;
        e.v    = ev;
        e.tag  = tag;
        sb_q.push_back(e);
    endtask

    task automatic drive(input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        logic [32:0] m;
        m = model(ins, a, b);
        drive_exp(ins, a, b, m[32], m[31:0], tag);
    endtask

    // monitor: compare at the falling edge after each drive
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (result !== e.res || valid !== e.v) begin
                n_fails++;
                $display("FAIL %s: actual valid=%0b result=%08h expected valid=%0b result=%08h",
                         e.tag, valid, result, e.v, e.res);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle state: all-zero word is a left shift by zero of zero (R5)
        drive_exp(32'h0, 32'h0, 32'h0, 1'b1, 32'h0, "R5 idle");

        // R1
        drive_exp(itype(6'h0F, 5'd3, 5'd9, 16'h7F40), 32'hDEADBEEF, 32'h12345678,
                  1'b1, 32'h7F40_0000, "R1 lui");
        drive_exp(itype(6'h0F, 5'd0, 5'd1, 16'hFFFF), 32'hFFFFFFFF, 32'h0,
                  1'b1, 32'hFFFF_0000, "R1 lui ones");
        // R4
        drive_exp(itype(6'h08, 5'd9, 5'd10, 16'h0777), 32'h7F40_0000, 32'h0,
                  1'b1, 32'h7F40_0777, "R4 addi");
        drive_exp(itype(6'h08, 5'd9, 5'd10, 16'hFFFF), 32'd5, 32'h0,
                  1'b1, 32'd4, "R4 addi negative");
        drive_exp(itype(6'h08, 5'd9, 5'd10, 16'h0001), 32'h7FFF_FFFF, 32'h0,
                  1'b1, 32'h8000_0000, "R4 addi wrap");
        drive_exp(itype(6'h08, 5'd9, 5'd10, 16'h0001), 32'hFFFF_FFFF, 32'h0,
                  1'b1, 32'h0, "R4 addi carry out");
        // R2
        drive_exp(itype(6'h0C, 5'd10, 5'd11, 16'h5555), 32'h7F40_0777, 32'h0,
                  1'b1, 32'h0000_0555, "R2 andi");
        drive_exp(itype(6'h0C, 5'd10, 5'd11, 16'h8000), 32'hFFFF_FFFF, 32'h0,
                  1'b1, 32'h0000_8000, "R2 andi zero ext");
        // R3
        drive_exp(itype(6'h0D, 5'd10, 5'd12, 16'h5555), 32'h7F40_0777, 32'h0,
                  1'b1, 32'h7F40_5777, "R3 ori");
        drive_exp(itype(6'h0D, 5'd10, 5'd12, 16'h8000), 32'h0, 32'h0,
                  1'b1, 32'h0000_8000, "R3 ori zero ext");
        // R9
        drive_exp(rtype(5'd0, 5'd8, 5'd3, 6'h00), 32'h0, 32'h77,
                  1'b1, 32'h0000_03B8, "R9 sll example");
        drive_exp(rtype(5'd0, 5'd10, 5'd2, 6'h02), 32'h0, 32'h3,
                  1'b1, 32'h0, "R9 srl example");
        // R5: rs field and rs_val ignored by fixed shifts
        drive_exp(rtype(5'd31, 5'd8, 5'd4, 6'h00), 32'hFFFF_FFFF, 32'h0000_00F1,
                  1'b1, 32'h0000_0F10, "R5 sll rs ignored");
        drive_exp(rtype(5'd31, 5'd8, 5'd8, 6'h02), 32'h0000_0003, 32'hA500_0000,
                  1'b1, 32'h00A5_0000, "R5 srl rs ignored");
        // R7
        drive_exp(rtype(5'd0, 5'd8, 5'd31, 6'h03), 32'h0, 32'h8000_0000,
                  1'b1, 32'hFFFF_FFFF, "R7 sra sign fill");
        drive_exp(rtype(5'd0, 5'd8, 5'd31, 6'h02), 32'h0, 32'h8000_0000,
                  1'b1, 32'h0000_0001, "R7 srl zero fill");
        drive_exp(rtype(5'd0, 5'd8, 5'd4, 6'h03), 32'h0, 32'h7000_0000,
                  1'b1, 32'h0700_0000, "R7 sra positive");
        drive_exp(rtype(5'd0, 5'd8, 5'd0, 6'h03), 32'h0, 32'h8123_4567,
                  1'b1, 32'h8123_4567, "R7 zero amount");
        // R6: field and upper register bits ignored
        drive_exp(rtype(5'd2, 5'd8, 5'd7, 6'h04), 32'hFFFF_FFE4, 32'h0000_0011,
                  1'b1, 32'h0000_0110, "R6 sllv");
        drive_exp(rtype(5'd2, 5'd8, 5'd1, 6'h06), 32'h0000_0FFF, 32'hF000_0000,
                  1'b1, 32'h0000_0001, "R6 srlv 31");
        drive_exp(rtype(5'd2, 5'd8, 5'd5, 6'h07), 32'hFFFF_FFE0, 32'h8000_0010,
                  1'b1, 32'h8000_0010, "R6 srav amount zero");
        drive_exp(rtype(5'd2, 5'd8, 5'd2, 6'h07), 32'h0000_0108, 32'h8000_0000,
                  1'b1, 32'hFF80_0000, "R6 srav");
        // R8
        drive_exp(rtype(5'd1, 5'd2, 5'd3, 6'h01), 32'h5, 32'h7, 1'b0, 32'h0, "R8 funct 01");
        drive_exp(rtype(5'd1, 5'd2, 5'd3, 6'h05), 32'h5, 32'h7, 1'b0, 32'h0, "R8 funct 05");
        drive_exp(rtype(5'd1, 5'd2, 5'd3, 6'h20), 32'h5, 32'h7, 1'b0, 32'h0, "R8 funct 20");
        drive_exp(itype(6'h09, 5'd1, 5'd2, 16'h1234), 32'h5, 32'h7, 1'b0, 32'h0, "R8 opcode 09");
        drive_exp(itype(6'h0E, 5'd1, 5'd2, 16'h1234), 32'h5, 32'h7, 1'b0, 32'h0, "R8 opcode 0E");
        drive_exp(itype(6'h23, 5'd1, 5'd2, 16'h1234), 32'h5, 32'h7, 1'b0, 32'h0, "R8 opcode 23");

        // mixed patterns against the model (R1..R8)
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 60; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            logic [31:0] ins;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a    = lfsr ^ 32'h5A5A_A5A5;
            b    = {lfsr[15:0], lfsr[31:16]};
            case (i % 6)
                0: ins = itype(6'h0F, lfsr[4:0], lfsr[9:5], lfsr[31:16]);
                1: ins = itype(6'h08, lfsr[4:0], lfsr[9:5], lfsr[15:0]);
                2: ins = itype(6'h0C, lfsr[4:0], lfsr[9:5], lfsr[23:8]);
                3: ins = itype(6'h0D, lfsr[4:0], lfsr[9:5], lfsr[27:12]);
                4: ins = rtype(lfsr[4:0], lfsr[9:5], lfsr[14:10], {3'b000, lfsr[17:15]});
                default: ins = {lfsr[31:26], lfsr[25:0]};
            endcase
            drive(ins, a, b, "R1-R8 mixed");
        end

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule